// File: doc/BRIEF.md
# Two-Channel Compare Match Timer

This block holds two independent 16-bit up-counters. Each counter has its own compare constant and its own control register. A single peripheral clock drives all of the logic. One free-running prescaler supplies enable strobes at 1/8, 1/32, 1/128 and 1/512 of that clock, and each channel picks one of them. When a running counter equals its constant on a count strobe, it returns to zero on that strobe. In the following clock cycle the channel can raise a one-cycle interrupt pulse. The count period is therefore (constant + 1) strobes.

A shared start register holds one run bit per channel. Channel 1 also has an event input and an event output. The input is edge-detected and acts in one of three modes. It can set the channel 1 run bit. It can replace the prescaler strobe, so the channel counts events. It can clear the count and set the run bit. The output pulses for one clock on every channel 1 match, whether or not the interrupt is enabled.

Software reaches every register through a small word-addressed write/read bus. A read returns the addressed register one clock after the address is presented.

Top module: `cmt_pair`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `irq` and `evt_out` are low.
- R2: Register map by `bus_addr`: 0 run bits (bit 0 channel 0, bit 1 channel 1); 1/2/3 channel 0 control, count and constant; 4/5/6 channel 1 control, count and constant. Control fields: bits [1:0] prescale select, bit 2 interrupt enable, bits [4:3] event mode. A read of address A presented before a clock edge appears on `bus_rdata` after that edge.
- R3: Prescale select 00, 01, 10, 11 advances a running counter once every 8, 32, 128 or 512 clocks.
- R4: A running counter counts 0..constant. On the strobe where it equals the constant it clears to 0, so matches repeat every (constant+1)·divisor clocks.
- R5: A channel whose run bit is 0 holds its count.
- R6: `irq[c]` is a one-clock pulse in the cycle after a match strobe, and only when that channel's interrupt enable is 1.
- R7: `evt_out` is a one-clock pulse on every channel 1 match, independent of the interrupt enable.
- R8: A count-register write loads the written value, and it takes priority over an increment or an event clear in the same cycle.
- R9: Event mode 01: a rising edge on `evt_in` sets the channel 1 run bit and keeps the count.
- R10: Event mode 10: channel 1 advances once per rising edge of `evt_in` (a level held high counts once), and its prescale select is ignored.
- R11: Event mode 11: a rising edge on `evt_in` clears the channel 1 count to 0 and sets its run bit.
- R12: Channel 0 stores no event mode (bits [4:3] read 0). Events never affect channel 0. With mode 00, events change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| evt_in | input | 1 | Channel 1 event input (synchronous) |
| irq | output | 2 | Per-channel match interrupt pulses |
| evt_out | output | 1 | Channel 1 match event pulse |

## Verification
On every cycle the assertions check the following:
- The prescaler strobes nest.
- A stopped channel holds its count.
- A count write always lands, ahead of any increment or clear.
- A match leaves the counter at zero.
- Interrupts are single-cycle and only follow a match.
- Start and restart events raise the channel 1 run bit.

Only the bench's scenarios can show the following:
- The actual match spacing for every prescale select, measured in clocks.
- The ignored clock select and edge counting in event-count mode.
- The missing interrupt when it is disabled while `evt_out` still pulses.
- That channel 0 stays untouched by events.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  typedef enum logic [1:0] {
    EV_OFF     = 2'b00,
    EV_START   = 2'b01,
    EV_COUNT   = 2'b10,
    EV_RESTART = 2'b11
  } ev_mode_e;

  typedef struct packed {
    ev_mode_e   mode;
    logic       irq_en;
    logic [1:0] div_sel;
  } ctrl_t;

  localparam int AW        = 3;
  localparam int CH_BASE   = 1;
  localparam int CH_STRIDE = 3;
  localparam int OFS_CTRL  = 0;
  localparam int OFS_CNT   = 1;
  localparam int OFS_CONST = 2;
  localparam logic [AW-1:0] A_RUN = '0;

  function automatic logic [AW-1:0] reg_addr(input int ch, input int ofs);
    return AW'(CH_BASE + CH_STRIDE * ch + ofs);
  endfunction

endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale #(
  parameter int BASE_LOG = 3,
  parameter int STEP_LOG = 2,
  parameter int NSEL     = 4
) (
  input  logic            clk,
  input  logic            rst,
  output logic [NSEL-1:0] tick
);
  localparam int PW = BASE_LOG + STEP_LOG * (NSEL - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_tap
    localparam int LW = BASE_LOG + STEP_LOG * k;
    assign tick[k] = &div_q[LW-1:0];
    if (k > 0) begin : g_nest
      // R3: a slower strobe coincides with every faster one
      p_nest_r3: assert property (@(posedge clk) disable iff (rst)
        tick[k] |-> tick[k-1]);
    end
  end

endmodule

// File: rtl/cmt_chan.sv
module cmt_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          step,
  input  logic          clr,
  input  logic          wr,
  input  logic [CW-1:0] wr_val,
  input  logic [CW-1:0] cmp,
  input  logic          ie,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o,
  output logic          irq_o
);
  logic adv, at_top;

  assign adv    = run & step & ~wr & ~clr;
  assign at_top = (cnt_o == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      hit_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      hit_o <= adv & at_top;
      irq_o <= adv & at_top & ie;
      if (wr)       cnt_o <= wr_val;
      else if (clr) cnt_o <= '0;
      else if (adv) cnt_o <= at_top ? '0 : cnt_o + 1'b1;
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr && !clr) |=> $stable(cnt_o));
  p_wr_first_r8: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cnt_o == $past(wr_val)));
  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (clr && !wr) |=> (cnt_o == '0));
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (cnt_o == '0));
  p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

endmodule

// File: rtl/cmt_pair.sv
module cmt_pair
  import cmt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int BASE_LOG = 3,
  parameter int STEP_LOG = 2,
  parameter int NSEL     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             evt_in,
  output logic [1:0]       irq,
  output logic             evt_out
);
  localparam int NCH    = 2;
  localparam int EVT_CH = 1;
  localparam int CTW    = $bits(ctrl_t);

  logic [NCH-1:0]   run_q;
  ctrl_t            ctrl_q  [NCH];
  logic [CNT_W-1:0] const_q [NCH];
  logic [CNT_W-1:0] cnt_w   [NCH];
  logic [NCH-1:0]   hit_w, step_w, clr_w, wr_w;
  logic [NSEL-1:0]  tick_w;
  logic             evt_d, evt_pulse, evt_arms;
  logic [CNT_W-1:0] rd_d;

  assign evt_pulse = evt_in & ~evt_d;
  assign evt_arms  = (ctrl_q[EVT_CH].mode == EV_START) ||
                     (ctrl_q[EVT_CH].mode == EV_RESTART);

  cmt_prescale #(.BASE_LOG(BASE_LOG), .STEP_LOG(STEP_LOG), .NSEL(NSEL)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      evt_d <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        ctrl_q[c]  <= '0;
        const_q[c] <= '0;
      end
    end else begin
      evt_d <= evt_in;
      if (bus_we && bus_addr == A_RUN) run_q <= bus_wdata[NCH-1:0];
      if (evt_pulse && evt_arms) run_q[EVT_CH] <= 1'b1;
      for (int c = 0; c < NCH; c++) begin
        if (bus_we && bus_addr == reg_addr(c, OFS_CTRL)) begin
          ctrl_q[c] <= ctrl_t'(bus_wdata[CTW-1:0]);
          if (c != EVT_CH) ctrl_q[c].mode <= EV_OFF;
        end
        if (bus_we && bus_addr == reg_addr(c, OFS_CONST))
          const_q[c] <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr == A_RUN) rd_d = {{(CNT_W-NCH){1'b0}}, run_q};
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == reg_addr(c, OFS_CTRL))  rd_d = {{(CNT_W-CTW){1'b0}}, ctrl_q[c]};
      if (bus_addr == reg_addr(c, OFS_CNT))   rd_d = cnt_w[c];
      if (bus_addr == reg_addr(c, OFS_CONST)) rd_d = const_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam bit IS_EVT = (c == EVT_CH);
    assign wr_w[c]   = bus_we && (bus_addr == reg_addr(c, OFS_CNT));
    assign step_w[c] = (IS_EVT && ctrl_q[c].mode == EV_COUNT) ? evt_pulse
                                                              : tick_w[ctrl_q[c].div_sel];
    assign clr_w[c]  = IS_EVT && (ctrl_q[c].mode == EV_RESTART) && evt_pulse;

    cmt_chan #(.CW(CNT_W)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .run   (run_q[c]),
      .step  (step_w[c]),
      .clr   (clr_w[c]),
      .wr    (wr_w[c]),
      .wr_val(bus_wdata),
      .cmp   (const_q[c]),
      .ie    (ctrl_q[c].irq_en),
      .cnt_o (cnt_w[c]),
      .hit_o (hit_w[c]),
      .irq_o (irq[c])
    );

    // R6: an interrupt only accompanies a match of the same channel
    p_irq_match_r6: assert property (@(posedge clk) disable iff (rst)
      irq[c] |-> hit_w[c]);
  end

  assign evt_out = hit_w[EVT_CH];

  p_evt_run_r9: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse && evt_arms) |=> run_q[EVT_CH]);
  p_evt_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse && ctrl_q[EVT_CH].mode == EV_OFF && !(bus_we && bus_addr == A_RUN))
      |=> $stable(run_q));

endmodule

// File: tb/tb_cmt_pair.sv
module tb_cmt_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        evt_in = 1'b0;
  logic [1:0]  irq;
  logic        evt_out;

  int checks = 0, failures = 0;
  int cyc = 0;
  int n_irq0 = 0, n_irq1 = 0, n_evt = 0;
  int t0_last = 0, t0_prev = 0, te_last = 0, te_prev = 0;
  int width_bad = 0;
  logic p_irq0 = 0, p_irq1 = 0, p_evt = 0;

  localparam logic [2:0] A_RUN = 0, A_CTL0 = 1, A_CNT0 = 2, A_CST0 = 3,
                         A_CTL1 = 4, A_CNT1 = 5, A_CST1 = 6;

  always #10 clk = ~clk;

  cmt_pair dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .irq(irq), .evt_out(evt_out)
  );

  always @(negedge clk) begin
    cyc++;
    if (irq[0]) begin n_irq0++; t0_prev = t0_last; t0_last = cyc; end
    if (irq[1]) n_irq1++;
    if (evt_out) begin n_evt++; te_prev = te_last; te_last = cyc; end
    if ((irq[0] && p_irq0) || (irq[1] && p_irq1) || (evt_out && p_evt)) width_bad++;
    p_irq0 = irq[0]; p_irq1 = irq[1]; p_evt = evt_out;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); bus_addr = a;
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic pulse_evt(input int hold);
    @(negedge clk); evt_in = 1'b1;
    repeat (hold) @(negedge clk);
    evt_in = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int base, lim, div, per;
    int cv[3] = '{0, 2, 5};

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(irq == 2'b00 && evt_out == 1'b0, "R1 outputs", int'(irq), 0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk(v == 16'h0, "R1 register", int'(v), 0);
    end

    // R2: readback of fields; R12: channel 0 drops the mode field
    wr(A_CST0, 16'hBEEF); rd(A_CST0, v); chk(v == 16'hBEEF, "R2 const0", int'(v), 'hBEEF);
    wr(A_CTL1, 16'h001E); rd(A_CTL1, v); chk(v == 16'h001E, "R2 ctrl1", int'(v), 'h1E);
    wr(A_CTL0, 16'h001F); rd(A_CTL0, v); chk(v == 16'h0007, "R12 ctrl0 mode", int'(v), 7);
    wr(A_CTL1, 16'h0000);

    // R3/R4/R6: channel 0 match spacing for every divisor and several constants
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 3; j++) begin
        div = 8 << (2 * k);
        per = (cv[j] + 1) * div;
        wr(A_RUN, 16'h0);
        idle(2);
        wr(A_CST0, 16'(cv[j]));
        wr(A_CTL0, 16'(k | 4));
        wr(A_CNT0, 16'h0);
        base = n_irq0;
        wr(A_RUN, 16'h1);
        lim = 0;
        while (n_irq0 < base + 2 && lim < 3 * per + 64) begin @(negedge clk); lim++; end
        chk(n_irq0 >= base + 2, "R6 irq seen", n_irq0 - base, 2);
        chk(t0_last - t0_prev == per, "R3 R4 interval", t0_last - t0_prev, per);
      end
    end
    wr(A_RUN, 16'h0);
    idle(4);

    // R7/R6: channel 1 with interrupt disabled still emits events
    for (int k = 0; k < 4; k++) begin
      div = 8 << (2 * k);
      per = 2 * div;
      wr(A_RUN, 16'h0);
      idle(2);
      wr(A_CST1, 16'd1);
      wr(A_CTL1, 16'(k));
      wr(A_CNT1, 16'h0);
      base = n_evt;
      lim = n_irq1;
      wr(A_RUN, 16'h2);
      while (n_evt < base + 2) @(negedge clk);
      chk(te_last - te_prev == per, "R7 evt interval", te_last - te_prev, per);
      chk(n_irq1 == lim, "R6 irq disabled", n_irq1 - lim, 0);
    end
    wr(A_RUN, 16'h0);
    idle(4);

    // R5: stopped channel holds
    wr(A_CNT0, 16'd7);
    idle(600);
    rd(A_CNT0, v); chk(v == 16'd7, "R5 hold", int'(v), 7);

    // R8: write while running loads value
    wr(A_CTL0, 16'h0003); wr(A_CST0, 16'hFFFF); wr(A_RUN, 16'h1);
    idle(40);
    wr(A_CNT0, 16'h1234);
    rd(A_CNT0, v); chk(v == 16'h1234, "R8 load running", int'(v), 'h1234);
    wr(A_RUN, 16'h0);
    wr(A_CNT0, 16'd9);

    // R12: mode off leaves channel 1 untouched
    wr(A_CTL1, 16'h0003); wr(A_CST1, 16'hFFFF); wr(A_CNT1, 16'd20);
    pulse_evt(1); idle(2);
    rd(A_RUN, v); chk(v == 16'h0, "R12 off run", int'(v), 0);
    rd(A_CNT1, v); chk(v == 16'd20, "R12 off count", int'(v), 20);

    // R9: start mode
    wr(A_CTL1, 16'h000B); wr(A_CNT1, 16'd50);
    pulse_evt(1);
    rd(A_RUN, v); chk(v == 16'h2, "R9 run set", int'(v), 2);
    rd(A_CNT1, v); chk(v == 16'd50 || v == 16'd51, "R9 count kept", int'(v), 50);
    wr(A_RUN, 16'h0);

    // R11: restart mode
    wr(A_CTL1, 16'h001B); wr(A_CNT1, 16'd100);
    pulse_evt(1);
    rd(A_RUN, v); chk(v == 16'h2, "R11 run set", int'(v), 2);
    rd(A_CNT1, v); chk(v <= 16'd1, "R11 cleared", int'(v), 0);
    wr(A_RUN, 16'h0);

    // R10: event count mode, divisor select /8 must have no effect
    wr(A_CTL1, 16'h0010); wr(A_CST1, 16'd3); wr(A_CNT1, 16'd0); wr(A_RUN, 16'h2);
    pulse_evt(1); idle(1);
    pulse_evt(10); idle(1);
    pulse_evt(1); idle(1);
    rd(A_CNT1, v); chk(v == 16'd3, "R10 three edges", int'(v), 3);
    idle(600);
    rd(A_CNT1, v); chk(v == 16'd3, "R10 no prescale", int'(v), 3);
    base = n_evt;
    pulse_evt(1); idle(3);
    chk(n_evt == base + 1, "R10 R7 match event", n_evt - base, 1);
    rd(A_CNT1, v); chk(v == 16'd0, "R10 R4 wrap", int'(v), 0);

    // R12: channel 0 unaffected by all the events
    rd(A_CNT0, v); chk(v == 16'd9, "R12 ch0 count", int'(v), 9);
    rd(A_RUN, v); chk(v[0] == 1'b0, "R12 ch0 run", int'(v[0]), 0);

    chk(width_bad == 0, "R6 R7 one-clock pulses", width_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule